// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block sits beside a PCI bridge's configuration space and turns the bytes that software writes there into interrupt steering. It gives each of the four PCI interrupt pins (INTA to INTD) an IRQ number on the legacy interrupt controllers, or leaves the pin unrouted. It also keeps the 16-bit edge/level control vector for the two cascaded legacy controllers. The low byte of that vector is for the primary controller and the high byte is for the secondary one.

Software writes single configuration bytes. Two routing bytes each hold two 4-bit pin fields. Each field's low three bits pick a code from a sparse table of seven legal IRQs. Two marking bytes hold four more fields that ask for level-triggered handling of the IRQ they name. A global enable bit in a separate control byte gates that request. The control vector is rebuilt only when the control byte or a byte in the routing window is written. A write to a marking byte is only stored.

The block drives the steering outputs and nothing else. The interrupt controllers and the synchronisation of interrupt signals lie outside it.

Top module: `pirq_router`

## Requirements
- R1: While reset is asserted and right after it, every pin valid flag is 0, every pin IRQ output is 0 and the control vector is 0.
- R2: A field's 3-bit code maps to an IRQ as follows: 1 gives 5, 2 gives 9, 3 gives 10, 4 gives 11, 5 gives 12, 6 gives 14 and 7 gives 15. A valid pin only ever carries one of these IRQs.
- R3: In a write to offset 0x88, bits 2:0 set INTA and bits 6:4 set INTB. In a write to offset 0x89, bits 2:0 set INTC and bits 6:4 set INTD. The pin outputs show the new value from the clock edge that takes the write.
- R4: A pin whose code is 0 has its valid flag low and its IRQ output 0. Bit 3 of a routing field (bit 3 or bit 7 of the byte) has no effect on that pin's outputs.
- R5: Writes to any offset other than 0x88 and 0x89 leave every pin output unchanged. This includes offsets 0x8A to 0x8F.
- R6: Level conversion is enabled by bit 3 of offset 0x53. After reset this bit is 0, which is the state given by a reset value of 0x90. While the bit is 0, a rebuild sets no bit of the control vector.
- R7: The four marking fields are bits 3:0 and 7:4 of offset 0x80, and bits 3:0 and 7:4 of offset 0x81. Bit k of the control vector belongs to IRQ k. Take a rebuild with conversion enabled, and a field with a nonzero code and bit 3 set. That rebuild sets the bit of the IRQ the field maps to.
- R8: In a rebuild, the bits of the IRQs mapped by nonzero marking fields are first cleared and then set again as R7 requires. The result is that a set request wins when two fields share an IRQ. Bits of IRQs that no field maps keep their value, and a field with code 0 touches nothing.
- R9: A rebuild happens on, and only on, a write to 0x53 or to any offset from 0x88 to 0x8F. The rebuild uses the value being written to 0x53 when that is the offset written. It takes effect at the same clock edge as the write. Writes to 0x80 and 0x81 on their own leave the control vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgData | input | 8 | Configuration write data |
| pinIrq | output | 16 | IRQ number per pin, 4 bits each, INTA in bits 3:0 |
| pinValid | output | 4 | Pin routed flag, INTA in bit 0 |
| elcrOut | output | 16 | Edge/level control vector, bit k for IRQ k |

## Verification
The bench builds the block with its default parameters: four pins, a 16-line control vector, 8-bit bytes and two marking slots. At this size a full sweep over every value of both routing bytes and every value of the first marking byte is cheap. That sweep reaches every code, every pin and the ignored bit 3 of the routing fields. The marking sweep pairs each byte with a varied second byte. It rotates the rebuild trigger between the control byte with conversion on, the control byte with conversion off, and an unused routing offset. This brings stale bits, shared IRQs and code-0 fields within reach of a model in the bench that computes the expected values arithmetically.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int ROUTE_IDX_W = 3;
  localparam int MARK_IDX_W  = 1;
  localparam int IRQ_W       = 4;
  localparam int CODE_W      = 3;

  // Decoded write strobes handed from control to datapath
  typedef struct packed {
    logic                   routeWr;
    logic [ROUTE_IDX_W-1:0] routeIdx;
    logic                   markWr;
    logic [MARK_IDX_W-1:0]  markIdx;
    logic                   convWr;
    logic                   recalc;
  } strobe_t;

  // Sparse steering table: code 0 means unrouted
  function automatic logic [IRQ_W-1:0] codeToIrq(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return 4'd5;
      3'd2:    return 4'd9;
      3'd3:    return 4'd10;
      3'd4:    return 4'd11;
      3'd5:    return 4'd12;
      3'd6:    return 4'd14;
      3'd7:    return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int ROUTE_BASE  = 'h88,
  parameter int ROUTE_SLOTS = 8,
  parameter int MARK_BASE   = 'h80,
  parameter int MARK_SLOTS  = 2,
  parameter int CONV_ADDR   = 'h53
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  output strobe_t           strb
);

  logic [ADDR_W-1:0] routeOff;
  logic [ADDR_W-1:0] markOff;
  logic              routeHit;
  logic              markHit;
  logic              convHit;

  always_comb begin
    routeOff = cfgAddr - ADDR_W'(ROUTE_BASE);
    markOff  = cfgAddr - ADDR_W'(MARK_BASE);
    routeHit = cfgWrEn && (routeOff < ADDR_W'(ROUTE_SLOTS));
    markHit  = cfgWrEn && (markOff < ADDR_W'(MARK_SLOTS));
    convHit  = cfgWrEn && (cfgAddr == ADDR_W'(CONV_ADDR));

    strb.routeWr  = routeHit;
    strb.routeIdx = routeOff[ROUTE_IDX_W-1:0];
    strb.markWr   = markHit;
    strb.markIdx  = markOff[MARK_IDX_W-1:0];
    strb.convWr   = convHit;
    // Any write in the routing window or to the control byte rebuilds the vector
    strb.recalc   = routeHit || convHit;
  end

endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_PINS   = 4,
  parameter int NUM_LINES  = 16,
  parameter int DATA_W     = 8,
  parameter int MARK_SLOTS = 2,
  parameter int CONV_BIT   = 3,
  parameter int CONV_RESET = 'h90
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NUM_PINS*IRQ_W-1:0] pinIrq,
  output logic [NUM_PINS-1:0]       pinValid,
  output logic [NUM_LINES-1:0]      elcrOut
);

  localparam int NIB_W      = DATA_W / 2;
  localparam int NUM_FIELDS = MARK_SLOTS * 2;
  localparam logic [DATA_W-1:0] CONV_RST_V = DATA_W'(CONV_RESET);
  localparam logic CONV_INIT = CONV_RST_V[CONV_BIT];

  logic [CODE_W-1:0]    pinCode [NUM_PINS];
  logic [DATA_W-1:0]    markReg [MARK_SLOTS];
  logic                 convEn;
  logic                 convNext;
  logic [NUM_LINES-1:0] elcrReg;
  logic [NUM_LINES-1:0] touchMask;
  logic [NUM_LINES-1:0] setMask;

  // Per-pin code storage; two pins share one routing byte
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinCode[i] <= '0;
      end else if (strb.routeWr && strb.routeIdx == ROUTE_IDX_W'(i / 2)) begin
        pinCode[i] <= wrData[(i % 2) * NIB_W +: CODE_W];
      end
    end
    assign pinIrq[i*IRQ_W +: IRQ_W] = codeToIrq(pinCode[i]);
    assign pinValid[i]              = (pinCode[i] != '0);
  end

  for (genvar k = 0; k < MARK_SLOTS; k++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        markReg[k] <= '0;
      end else if (strb.markWr && strb.markIdx == MARK_IDX_W'(k)) begin
        markReg[k] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convEn <= CONV_INIT;
    end else if (strb.convWr) begin
      convEn <= wrData[CONV_BIT];
    end
  end

  // The enable used by a rebuild is the one being written, if any
  assign convNext = strb.convWr ? wrData[CONV_BIT] : convEn;

  // Clear-then-set masks over the marking fields
  always_comb begin
    logic [NIB_W-1:0]  nib;
    logic [CODE_W-1:0] code;
    logic [IRQ_W-1:0]  line;
    touchMask = '0;
    setMask   = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      nib  = markReg[f / 2][(f % 2) * NIB_W +: NIB_W];
      code = nib[CODE_W-1:0];
      line = codeToIrq(code);
      if (code != '0) begin
        touchMask[line] = 1'b1;
        if (convNext && nib[NIB_W-1]) begin
          setMask[line] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elcrReg <= '0;
    end else if (strb.recalc) begin
      elcrReg <= (elcrReg & ~touchMask) | setMask;
    end
  end

  assign elcrOut = elcrReg;

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_PINS    = 4,
  parameter int NUM_LINES   = 16,
  parameter int ROUTE_BASE  = 'h88,
  parameter int ROUTE_SLOTS = 8,
  parameter int MARK_BASE   = 'h80,
  parameter int MARK_SLOTS  = 2,
  parameter int CONV_ADDR   = 'h53,
  parameter int CONV_BIT    = 3,
  parameter int CONV_RESET  = 'h90
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [DATA_W-1:0]         cfgData,
  output logic [NUM_PINS*IRQ_W-1:0] pinIrq,
  output logic [NUM_PINS-1:0]       pinValid,
  output logic [NUM_LINES-1:0]      elcrOut
);

  strobe_t strb;

  pirq_ctrl #(
    .ADDR_W     (ADDR_W),
    .ROUTE_BASE (ROUTE_BASE),
    .ROUTE_SLOTS(ROUTE_SLOTS),
    .MARK_BASE  (MARK_BASE),
    .MARK_SLOTS (MARK_SLOTS),
    .CONV_ADDR  (CONV_ADDR)
  ) u_ctrl (
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .strb   (strb)
  );

  pirq_datapath #(
    .NUM_PINS  (NUM_PINS),
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .MARK_SLOTS(MARK_SLOTS),
    .CONV_BIT  (CONV_BIT),
    .CONV_RESET(CONV_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (cfgData),
    .pinIrq  (pinIrq),
    .pinValid(pinValid),
    .elcrOut (elcrOut)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_PINS    = 4,
  parameter int NUM_LINES   = 16,
  parameter int ROUTE_BASE  = 'h88,
  parameter int ROUTE_SLOTS = 8,
  parameter int CONV_ADDR   = 'h53,
  parameter int CONV_BIT    = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      cfgWrEn,
  input logic [ADDR_W-1:0]         cfgAddr,
  input logic [DATA_W-1:0]         cfgData,
  input logic [NUM_PINS*IRQ_W-1:0] pinIrq,
  input logic [NUM_PINS-1:0]       pinValid,
  input logic [NUM_LINES-1:0]      elcrOut
);

  localparam int PIN_BYTES = (NUM_PINS + 1) / 2;

  function automatic logic [NUM_LINES-1:0] legalLines();
    logic [NUM_LINES-1:0] m;
    m = '0;
    for (int c = 1; c < 8; c++) m[codeToIrq(CODE_W'(c))] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_LINES-1:0] LEGAL = legalLines();

  logic [ADDR_W-1:0] offs;
  logic              pinWrite;
  logic              rebuildWrite;
  logic              convOffWrite;

  assign offs         = cfgAddr - ADDR_W'(ROUTE_BASE);
  assign pinWrite     = cfgWrEn && (offs < ADDR_W'(PIN_BYTES));
  assign rebuildWrite = cfgWrEn && ((offs < ADDR_W'(ROUTE_SLOTS)) || (cfgAddr == ADDR_W'(CONV_ADDR)));
  assign convOffWrite = cfgWrEn && (cfgAddr == ADDR_W'(CONV_ADDR)) && !cfgData[CONV_BIT];

  // R1: reset clears every output
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (pinValid == '0 && pinIrq == '0 && elcrOut == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R2: a routed pin carries a legal IRQ
    p_legal_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
      pinValid[i] |-> LEGAL[pinIrq[i*IRQ_W +: IRQ_W]]);
    // R4: an unrouted pin shows IRQ 0
    p_unrouted_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      !pinValid[i] |-> (pinIrq[i*IRQ_W +: IRQ_W] == '0));
  end

  // R5: pins only move on a write to a pin-carrying routing byte
  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pinWrite |=> ($stable(pinIrq) && $stable(pinValid)));

  // R6: a control-byte write with conversion off sets no new bit
  p_conv_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    convOffWrite |=> ((elcrOut & ~$past(elcrOut)) == '0));

  // R7: only IRQs of the table ever appear in the control vector
  p_elcr_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    (elcrOut & ~LEGAL) == '0);

  // R9: without a rebuild write the vector holds
  p_elcr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rebuildWrite |=> $stable(elcrOut));

endmodule

bind pirq_router pirq_router_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .NUM_PINS   (NUM_PINS),
  .NUM_LINES  (NUM_LINES),
  .ROUTE_BASE (ROUTE_BASE),
  .ROUTE_SLOTS(ROUTE_SLOTS),
  .CONV_ADDR  (CONV_ADDR),
  .CONV_BIT   (CONV_BIT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWrEn (cfgWrEn),
  .cfgAddr (cfgAddr),
  .cfgData (cfgData),
  .pinIrq  (pinIrq),
  .pinValid(pinValid),
  .elcrOut (elcrOut)
);

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic [15:0] pinIrq;
  logic [3:0]  pinValid;
  logic [15:0] elcrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0]  mRoute [2];
  logic [7:0]  mMark  [2];
  bit          mConv;
  logic [15:0] mElcr;

  always #4 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .pinIrq(pinIrq), .pinValid(pinValid), .elcrOut(elcrOut)
  );

  function automatic logic [3:0] expIrq(input int code);
    if (code == 0) return 4'd0;
    if (code == 1) return 4'd5;
    if (code <= 5) return 4'(code + 7);
    return 4'(code + 8);
  endfunction

  function automatic void modelRebuild();
    logic [15:0] touch = '0;
    logic [15:0] setm = '0;
    for (int f = 0; f < 4; f++) begin
      int nib = (mMark[f / 2] >> (4 * (f % 2))) & 15;
      int code = nib & 7;
      if (code != 0) begin
        touch[expIrq(code)] = 1'b1;
        if (mConv && nib >= 8) setm[expIrq(code)] = 1'b1;
      end
    end
    mElcr = (mElcr & ~touch) | setm;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = a;
    cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 8'h88) mRoute[0] = d;
    if (a == 8'h89) mRoute[1] = d;
    if (a == 8'h80) mMark[0] = d;
    if (a == 8'h81) mMark[1] = d;
    if (a == 8'h53) mConv = d[3];
    if (a == 8'h53 || (a >= 8'h88 && a <= 8'h8F)) modelRebuild();
  endtask

  task automatic checkPins(input string req);
    for (int p = 0; p < 4; p++) begin
      int code = (mRoute[p / 2] >> (4 * (p % 2))) & 7;
      check(req, $sformatf("pin%0d valid", p), int'(pinValid[p]), int'(code != 0));
      check(req, $sformatf("pin%0d irq", p), int'(pinIrq[p*4 +: 4]), int'(expIrq(code)));
    end
  endtask

  task automatic checkElcr(input string req);
    check(req, "elcr", int'(elcrOut), int'(mElcr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mRoute[0] = '0; mRoute[1] = '0; mMark[0] = '0; mMark[1] = '0;
    mConv = 1'b0; mElcr = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "valid in reset", int'(pinValid), 0);
    check("R1", "elcr in reset", int'(elcrOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkPins("R1");
    checkElcr("R1");

    // R6: conversion starts disabled, so a rebuild sets nothing
    wr(8'h80, 8'h99);
    checkElcr("R9");
    wr(8'h88, 8'h00);
    checkElcr("R6");
    check("R6", "elcr after rebuild while off", int'(elcrOut), 0);
    // R7: enable conversion through the control byte (level request on IRQ5)
    wr(8'h53, 8'h98);
    check("R7", "IRQ5 level bit", int'(elcrOut), 16'h0020);
    // R9: a marking write on its own leaves the vector alone
    wr(8'h80, 8'h00);
    check("R9", "elcr after mark-only write", int'(elcrOut), 16'h0020);
    checkElcr("R9");

    // R2 R3 R4: full sweep of both routing bytes
    for (int v = 0; v < 256; v++) begin
      wr(8'h88, 8'(v));
      checkPins("R3");
      wr(8'h89, 8'(v) ^ 8'h5A);
      checkPins("R2");
    end
    wr(8'h88, 8'h8F);
    checkPins("R4");

    // R5: other offsets leave the pins unchanged
    wr(8'h88, 8'h73);
    wr(8'h89, 8'h26);
    begin
      logic [7:0] others [9] = '{8'h87, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h8E, 8'h8F, 8'h90, 8'hFF};
      for (int k = 0; k < 9; k++) begin
        wr(others[k], 8'hFF);
        checkPins("R5");
        checkElcr("R9");
      end
    end

    // R7 R8 R9: marking sweep with rotating rebuild triggers
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mb = 8'(m);
      wr(8'h80, mb);
      wr(8'h81, {mb[3:0], mb[7:4]} ^ 8'h3C);
      checkElcr("R9");
      case (m % 3)
        0: begin wr(8'h53, 8'h98); checkElcr("R7"); end
        1: begin wr(8'h8C, mb);    checkElcr("R9"); end
        default: begin wr(8'h53, 8'h90); checkElcr("R8"); end
      endcase
    end

    // R8: two fields on IRQ10, one asks for level, the set wins
    wr(8'h81, 8'h00);
    wr(8'h80, 8'h3B);
    wr(8'h53, 8'h98);
    check("R8", "shared IRQ10 bit", int'(elcrOut[10]), 1);
    checkElcr("R8");
    // R8: code-0 fields leave an unmapped bit alone
    wr(8'h80, 8'h80);
    wr(8'h53, 8'h98);
    check("R8", "IRQ10 bit kept with no mapping", int'(elcrOut[10]), 1);
    checkElcr("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule